// File: doc/BRIEF.md
# Sequential block-write configuration register slave

This block is the serial-bus front end of a small configuration store. It holds 21 byte-wide registers and answers two addresses on a two-wire I2C/SMBus-style bus. The block oversamples SCL and SDA with a system clock. It models its open-drain data pin as a pull-low enable (`sda_oe`) plus the sampled line (`sda_i`).

There is no register addressing. Writes are block writes only. After the write address, the first two bytes are acknowledged and thrown away. Every later byte lands in the next register, counting up from register 0, until STOP. Reads work the same way. The slave first sends the byte-count register and then registers 0, 1, 2 and onward. The highest index sent is whichever is smaller: the value in the byte-count register, or 20.

Two register pairs are written atomically. The divider pair (11, 12) and the spread pair (13, 14) each take effect only when both of their bytes arrive in one transaction. On each such commit the block pulses a strobe. Other logic on the chip reads any register through a side port. It also gets the two divider values decoded from the divider pair.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset, register 7 reads 20h, register 8 reads 08h, every other register reads 00h, and `sda_oe` is low.
- R2: The slave acknowledges address byte D2h (write) and D3h (read). Any other address byte is not acknowledged, and the slave then drives nothing and writes nothing until the next START.
- R3: In a write, the two bytes after the address are acknowledged and discarded. Each later byte is acknowledged and stored in the next register, starting at register 0.
- R4: A STOP after any complete byte ends the write. Bytes already stored stay, and later registers keep their values.
- R5: Data bytes beyond register 20 are acknowledged and have no effect on any register.
- R6: Register 7 is read-only. It keeps reading 20h after any write.
- R7: A write of 00h to register 8 is ignored, so register 8 is never 00h.
- R8: Registers 11 and 12 change only together, and so do 13 and 14, when both bytes of the pair are written in one transaction. A lone low byte is discarded. A commit raises `pair_commit[0]` (pair 11/12) or `pair_commit[1]` (pair 13/14) for exactly one cycle, and never both at once.
- R9: A read returns the value of register 8 first. It then returns registers 0 up to index min(register 8, 20), in order, and 0FFh for any byte after that.
- R10: When the host does not acknowledge a read byte, the slave releases SDA and keeps it released. After STOP, `sda_oe` is low on the next cycle.
- R11: `vco_div` equals the 9-bit value {register 12, register 11 bit 7} plus 8. `ref_div` equals register 11 bits 6:0 plus 2.
- R12: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High pulls the data line low |
| cfg_idx | input | IDX_W (5) | Register index for the side read port |
| cfg_data | output | 8 | Register contents at `cfg_idx`; 0FFh when the index is out of range |
| pair_commit | output | PAIR_COUNT (2) | One-cycle strobe per atomic pair on commit |
| vco_div | output | 10 | Decoded feedback divider |
| ref_div | output | 8 | Decoded reference divider |

## Verification
The assertions check on every cycle that the data pin changes only while SCL is low, and that it stays released while the slave ignores the bus and right after a STOP. They also check that the commit strobes are single-cycle and mutually exclusive, and that the byte-count register is never zero. Only the bench scenarios can show that the two dummy bytes are discarded, that bytes land in order, and that an unfinished pair is dropped. The same holds for the clamping of the read length, the 0FFh fill past the end, and the decoded divider values.

// File: rtl/cfg_slave_pkg.sv
package cfg_slave_pkg;

  typedef enum logic [3:0] {
    BS_IDLE,
    BS_ADDR,
    BS_ADDR_END,
    BS_ADDR_ACK,
    BS_RX,
    BS_RX_END,
    BS_RX_ACK,
    BS_TX,
    BS_TX_HACK,
    BS_TX_NEXT,
    BS_IGNORE
  } bus_state_t;

  typedef enum logic [1:0] {
    WP_CMD,
    WP_CNT,
    WP_DATA
  } wr_phase_t;

  // feedback divider: nine programmed bits plus a fixed offset of 8
  function automatic logic [9:0] vco_div_of(input logic [7:0] lo, input logic [7:0] hi);
    return {1'b0, hi, lo[7]} + 10'd8;
  endfunction

  // reference divider: seven programmed bits plus a fixed offset of 2
  function automatic logic [7:0] ref_div_of(input logic [7:0] lo);
    return {1'b0, lo[6:0]} + 8'd2;
  endfunction

endpackage

// File: rtl/cfg_bus_sync.sv
module cfg_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int NUM_REGS = 21,
  parameter int IDX_W = 5,
  parameter int ID_IDX = 7,
  parameter logic [7:0] ID_VALUE = 8'h20,
  parameter int CNT_IDX = 8,
  parameter logic [7:0] CNT_RESET = 8'h08,
  parameter int PAIR_BASE = 11,
  parameter int PAIR_COUNT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_stb,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic                  txn_end,
  input  logic [IDX_W-1:0]      bus_idx,
  output logic [7:0]            bus_data,
  input  logic [IDX_W-1:0]      cfg_idx,
  output logic [7:0]            cfg_data,
  output logic [7:0]            cnt_value,
  output logic [7:0]            div_lo,
  output logic [7:0]            div_hi,
  output logic [PAIR_COUNT-1:0] commit
);
  localparam logic [IDX_W-1:0] END_IDX = IDX_W'(NUM_REGS);

  logic [7:0] regs [NUM_REGS];
  logic [7:0] stage_d [PAIR_COUNT];
  logic [PAIR_COUNT-1:0] stage_v;
  logic [PAIR_COUNT-1:0] lo_hit, hi_hit;
  logic plain_ok;

  function automatic logic [7:0] reset_value(input int i);
    if (i == ID_IDX)  return ID_VALUE;
    if (i == CNT_IDX) return CNT_RESET;
    return 8'h00;
  endfunction

  always_comb begin
    for (int p = 0; p < PAIR_COUNT; p++) begin
      lo_hit[p] = wr_stb && (wr_idx == IDX_W'(PAIR_BASE + 2 * p));
      hi_hit[p] = wr_stb && (wr_idx == IDX_W'(PAIR_BASE + 2 * p + 1));
    end
    plain_ok = wr_stb && !(|lo_hit) && !(|hi_hit) && (wr_idx < END_IDX)
               && (wr_idx != IDX_W'(ID_IDX))
               && !((wr_idx == IDX_W'(CNT_IDX)) && (wr_data == 8'h00));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= reset_value(i);
      for (int p = 0; p < PAIR_COUNT; p++) stage_d[p] <= 8'h00;
      stage_v <= '0;
      commit  <= '0;
    end else begin
      commit <= '0;
      if (txn_end) stage_v <= '0;
      for (int p = 0; p < PAIR_COUNT; p++) begin
        if (lo_hit[p]) begin
          stage_d[p] <= wr_data;
          stage_v[p] <= 1'b1;
        end else if (hi_hit[p] && stage_v[p]) begin
          regs[PAIR_BASE + 2 * p]     <= stage_d[p];
          regs[PAIR_BASE + 2 * p + 1] <= wr_data;
          commit[p]  <= 1'b1;
          stage_v[p] <= 1'b0;
        end
      end
      if (plain_ok) regs[wr_idx] <= wr_data;
    end
  end

  assign bus_data  = (bus_idx < END_IDX) ? regs[bus_idx] : 8'hFF;
  assign cfg_data  = (cfg_idx < END_IDX) ? regs[cfg_idx] : 8'hFF;
  assign cnt_value = regs[CNT_IDX];
  assign div_lo    = regs[PAIR_BASE];
  assign div_hi    = regs[PAIR_BASE + 1];
endmodule

// File: rtl/cfg_bus_engine.sv
module cfg_bus_engine #(
  parameter int NUM_REGS = 21,
  parameter int IDX_W = 5,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [7:0]       rd_data,
  input  logic [7:0]       cnt_value,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_stb,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             txn_end,
  output logic             sda_oe,
  output logic             bus_ignored
);
  import cfg_slave_pkg::*;

  localparam logic [IDX_W-1:0] END_IDX  = IDX_W'(NUM_REGS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  bus_state_t       state;
  wr_phase_t        wphase;
  logic [2:0]       bit_cnt;
  logic [7:0]       shreg;
  logic [6:0]       txsh;
  logic             is_read;
  logic [IDX_W-1:0] widx, rptr;
  logic [7:0]       rx_byte, next_tx;

  // highest register index a read returns
  function automatic logic [IDX_W-1:0] read_limit(input logic [7:0] cnt);
    if (cnt >= 8'(NUM_REGS - 1)) return LAST_IDX;
    return cnt[IDX_W-1:0];
  endfunction

  assign rx_byte     = {shreg[6:0], sda_s};
  assign next_tx     = (rptr <= read_limit(cnt_value)) ? rd_data : 8'hFF;
  assign rd_idx      = rptr;
  assign bus_ignored = (state == BS_IGNORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= BS_IDLE;
      wphase  <= WP_CMD;
      bit_cnt <= 3'd0;
      shreg   <= 8'h00;
      txsh    <= 7'h00;
      is_read <= 1'b0;
      widx    <= '0;
      rptr    <= '0;
      wr_stb  <= 1'b0;
      wr_idx  <= '0;
      wr_data <= 8'h00;
      txn_end <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      wr_stb  <= 1'b0;
      txn_end <= 1'b0;
      if (stop_evt) begin
        state   <= BS_IDLE;
        sda_oe  <= 1'b0;
        txn_end <= 1'b1;
      end else if (start_evt) begin
        state   <= BS_ADDR;
        sda_oe  <= 1'b0;
        bit_cnt <= 3'd0;
        txn_end <= 1'b1;
      end else begin
        case (state)
          BS_ADDR: if (scl_rise) begin
            shreg   <= rx_byte;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) state <= BS_ADDR_END;
          end
          BS_ADDR_END: if (scl_fall) begin
            if (shreg[7:1] == DEV_ADDR) begin
              sda_oe  <= 1'b1;
              is_read <= shreg[0];
              state   <= BS_ADDR_ACK;
            end else begin
              state <= BS_IGNORE;
            end
          end
          BS_ADDR_ACK: if (scl_fall) begin
            bit_cnt <= 3'd0;
            if (is_read) begin
              txsh   <= cnt_value[6:0];
              sda_oe <= ~cnt_value[7];
              rptr   <= '0;
              state  <= BS_TX;
            end else begin
              sda_oe <= 1'b0;
              wphase <= WP_CMD;
              widx   <= '0;
              state  <= BS_RX;
            end
          end
          BS_RX: if (scl_rise) begin
            shreg   <= rx_byte;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              state <= BS_RX_END;
              case (wphase)
                WP_CMD:  wphase <= WP_CNT;
                WP_CNT:  wphase <= WP_DATA;
                default: if (widx != END_IDX) begin
                  wr_stb  <= 1'b1;
                  wr_idx  <= widx;
                  wr_data <= rx_byte;
                  widx    <= widx + 1'b1;
                end
              endcase
            end
          end
          BS_RX_END: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= BS_RX_ACK;
          end
          BS_RX_ACK: if (scl_fall) begin
            sda_oe  <= 1'b0;
            bit_cnt <= 3'd0;
            state   <= BS_RX;
          end
          BS_TX: if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              sda_oe <= 1'b0;
              state  <= BS_TX_HACK;
            end else begin
              sda_oe  <= ~txsh[6];
              txsh    <= {txsh[5:0], 1'b0};
              bit_cnt <= bit_cnt + 3'd1;
            end
          end
          BS_TX_HACK: if (scl_rise) begin
            state <= sda_s ? BS_IGNORE : BS_TX_NEXT;
          end
          BS_TX_NEXT: if (scl_fall) begin
            txsh    <= next_tx[6:0];
            sda_oe  <= ~next_tx[7];
            bit_cnt <= 3'd0;
            if (rptr != END_IDX) rptr <= rptr + 1'b1;
            state   <= BS_TX;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
  parameter int NUM_REGS = 21,
  parameter int SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int ID_IDX = 7,
  parameter logic [7:0] ID_VALUE = 8'h20,
  parameter int CNT_IDX = 8,
  parameter logic [7:0] CNT_RESET = 8'h08,
  parameter int PAIR_BASE = 11,
  parameter int PAIR_COUNT = 2,
  localparam int IDX_W = $clog2(NUM_REGS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic [IDX_W-1:0]      cfg_idx,
  output logic [7:0]            cfg_data,
  output logic [PAIR_COUNT-1:0] pair_commit,
  output logic [9:0]            vco_div,
  output logic [7:0]            ref_div
);
  import cfg_slave_pkg::*;

  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic wr_stb, txn_end, bus_ignored;
  logic [IDX_W-1:0] wr_idx, bus_idx;
  logic [7:0] wr_data, bus_data, count_reg, div_lo, div_hi;

  cfg_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  cfg_bus_engine #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_data(bus_data), .cnt_value(count_reg), .rd_idx(bus_idx),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
    .txn_end(txn_end), .sda_oe(sda_oe), .bus_ignored(bus_ignored)
  );

  cfg_reg_bank #(
    .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .ID_IDX(ID_IDX), .ID_VALUE(ID_VALUE),
    .CNT_IDX(CNT_IDX), .CNT_RESET(CNT_RESET), .PAIR_BASE(PAIR_BASE),
    .PAIR_COUNT(PAIR_COUNT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .wr_data(wr_data), .txn_end(txn_end), .bus_idx(bus_idx),
    .bus_data(bus_data), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .cnt_value(count_reg), .div_lo(div_lo), .div_hi(div_hi),
    .commit(pair_commit)
  );

  assign vco_div = vco_div_of(div_lo, div_hi);
  assign ref_div = ref_div_of(div_lo);
endmodule

// File: rtl/cfg_slave_checks.sv
module cfg_slave_checks #(
  parameter int PAIR_COUNT = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_i,
  input logic                  sda_oe,
  input logic [PAIR_COUNT-1:0] pair_commit,
  input logic                  stop_seen,
  input logic                  bus_ignored,
  input logic [7:0]            count_reg
);
  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  p_commit_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pair_commit));

  p_commit_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|pair_commit) |=> (pair_commit == '0));

  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !sda_oe);

  p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ignored |-> !sda_oe);

  p_count_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count_reg != 8'h00);
endmodule

bind cfg_serial_slave cfg_slave_checks #(.PAIR_COUNT(PAIR_COUNT)) u_checks (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .pair_commit(pair_commit), .stop_seen(stop_evt),
  .bus_ignored(bus_ignored), .count_reg(count_reg)
);

// File: tb/tb_cfg_serial_slave.sv
module tb_cfg_serial_slave;
  localparam int NREG = 21;
  localparam int H = 12;

  // table walk: {data written, value expected back}; index 7 is read-only
  localparam logic [15:0] VEC [NREG] = '{
    16'hA0A0, 16'hA1A1, 16'hA2A2, 16'hA3A3, 16'hA4A4, 16'hA5A5, 16'hA6A6,
    16'hA720, 16'h0C0C, 16'hA9A9, 16'hAAAA, 16'hABAB, 16'hACAC, 16'hADAD,
    16'hAEAE, 16'hAFAF, 16'hB0B0, 16'hB1B1, 16'hB2B2, 16'hB3B3, 16'hB4B4
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_low = 1'b0;
  logic dut_oe;
  logic sda_line;
  logic [4:0] cfg_idx = '0;
  logic [7:0] cfg_data;
  logic [1:0] pair_commit;
  logic [9:0] vco_div;
  logic [7:0] ref_div;

  assign sda_line = !(host_low || dut_oe);

  cfg_serial_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(dut_oe),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .pair_commit(pair_commit),
    .vco_div(vco_div), .ref_div(ref_div)
  );

  int checks = 0, failures = 0;
  int c0 = 0, c1 = 0, oe_bad = 0;
  logic oe_prev = 1'b0;
  logic done = 1'b0;
  logic [7:0] mdl [NREG];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];
  int wlen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pair_commit[0]) c0++;
      if (pair_commit[1]) c1++;
      if (dut_oe != oe_prev && scl) oe_bad++;
    end
    oe_prev <= dut_oe;
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    host_low = !b; ticks(H); scl = 1'b1; ticks(H); scl = 1'b0; ticks(6);
  endtask

  task automatic get_bit(output logic b);
    host_low = 1'b0; ticks(H); scl = 1'b1; ticks(H / 2); b = sda_line;
    ticks(H - H / 2); scl = 1'b0; ticks(6);
  endtask

  task automatic bus_start();
    host_low = 1'b0; ticks(H); scl = 1'b1; ticks(H); host_low = 1'b1; ticks(H);
    scl = 1'b0; ticks(6);
  endtask

  task automatic bus_stop();
    host_low = 1'b1; ticks(H); scl = 1'b1; ticks(H); host_low = 1'b0; ticks(H);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic nb;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(nb);
    ack = !nb;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(!give_ack);
  endtask

  task automatic peek(input int idx, output logic [7:0] v);
    cfg_idx = 5'(idx); ticks(1); v = cfg_data;
  endtask

  // own model of the register rules
  task automatic model_write();
    for (int i = 0; i < wlen && i < NREG; i++) begin
      if (i == 12 || i == 14) continue;
      if (i == 11 || i == 13) begin
        if (i + 1 < wlen) begin mdl[i] = wbuf[i]; mdl[i + 1] = wbuf[i + 1]; end
      end else if (i == 7) begin
      end else if (i == 8 && wbuf[i] == 8'h00) begin
      end else begin
        mdl[i] = wbuf[i];
      end
    end
  endtask

  task automatic do_write(output int acks);
    logic a;
    acks = 0;
    bus_start();
    send_byte(8'hD2, a); acks += int'(a);
    send_byte(8'h5A, a); acks += int'(a);
    send_byte(8'h77, a); acks += int'(a);
    for (int i = 0; i < wlen; i++) begin send_byte(wbuf[i], a); acks += int'(a); end
    bus_stop();
    model_write();
  endtask

  function automatic logic [7:0] exp_rd(input int k);
    int last;
    last = (int'(mdl[8]) > NREG - 1) ? NREG - 1 : int'(mdl[8]);
    if (k == 0) return mdl[8];
    if (k - 1 <= last) return mdl[k - 1];
    return 8'hFF;
  endfunction

  task automatic do_read(input int n, input string tag);
    logic a;
    bus_start();
    send_byte(8'hD3, a);
    check({"R2 read address ack ", tag}, a, 1);
    for (int k = 0; k < n; k++) recv_byte(rbuf[k], k != n - 1);
    ticks(4);
    check({"R10 released after host NACK ", tag}, dut_oe, 0);
    ticks(H);
    check({"R10 still released ", tag}, dut_oe, 0);
    bus_stop();
    for (int k = 0; k < n; k++) check({"R9 read byte ", tag}, rbuf[k], exp_rd(k));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic a;
    int acks;
    for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
    mdl[7] = 8'h20; mdl[8] = 8'h08;
    ticks(5);
    rst_n = 1'b1;
    ticks(5);

    // R1 reset state
    check("R1 sda_oe after reset", dut_oe, 0);
    peek(0, v);  check("R1 reg0 reset", v, 8'h00);
    peek(7, v);  check("R1 reg7 reset", v, 8'h20);
    peek(8, v);  check("R1 reg8 reset", v, 8'h08);
    peek(20, v); check("R1 reg20 reset", v, 8'h00);
    check("R11 vco_div at reset", vco_div, 10'd8);
    check("R11 ref_div at reset", ref_div, 8'd2);

    // R9 default read length: count, regs 0..8, then fill
    do_read(11, "default");

    // R3 table walk: full block write
    wlen = NREG;
    for (int i = 0; i < NREG; i++) wbuf[i] = VEC[i][15:8];
    do_write(acks);
    check("R3 acks on full write", acks, NREG + 3);
    for (int i = 0; i < NREG; i++) begin
      peek(i, v);
      check("R3 table register value", v, VEC[i][7:0]);
    end
    check("R8 divider pair commit count", c0, 1);
    check("R8 spread pair commit count", c1, 1);
    check("R11 vco_div decode", vco_div,
          10'((int'(mdl[12]) * 2 + int'(mdl[11] >> 7)) + 8));
    check("R11 ref_div decode", ref_div, 8'((int'(mdl[11]) % 128) + 2));

    // R9 read with count 0Ch
    do_read(15, "count 0C");

    // R4 stop after three data bytes
    wlen = 3; wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(acks);
    check("R4 acks on short write", acks, 6);
    peek(2, v); check("R4 last written register", v, 8'h33);
    peek(3, v); check("R4 register after stop untouched", v, 8'hA3);

    // R8 lone low byte of divider pair is discarded
    wlen = 12;
    for (int i = 0; i < 11; i++) wbuf[i] = mdl[i];
    wbuf[11] = 8'h55;
    do_write(acks);
    peek(11, v); check("R8 lone low byte discarded", v, 8'hAB);
    check("R8 no commit on lone byte", c0, 1);
    check("R11 divider unchanged after lone byte", ref_div, 8'h2D);

    // R6, R7 read-only ID and zero count write
    wlen = 9;
    for (int i = 0; i < 9; i++) wbuf[i] = mdl[i];
    wbuf[7] = 8'hFF; wbuf[8] = 8'h00;
    do_write(acks);
    peek(7, v); check("R6 reg7 stays fixed", v, 8'h20);
    peek(8, v); check("R7 zero count write ignored", v, 8'h0C);

    // R5 overrun past register 20, count set to 19h
    wlen = 23;
    for (int i = 0; i < 23; i++) wbuf[i] = 8'(8'h30 + i);
    wbuf[8] = 8'h19;
    do_write(acks);
    check("R5 overrun bytes acknowledged", acks, 26);
    peek(20, v); check("R5 reg20 not overwritten", v, 8'h44);
    peek(11, v); check("R8 pair written with both bytes", v, 8'h3B);
    check("R8 pair commit after overrun write", c0, 2);

    // R2 foreign address ignored
    bus_start();
    send_byte(8'hA4, a);
    check("R2 foreign address not acknowledged", a, 0);
    send_byte(8'h00, a);
    check("R2 later byte not acknowledged", a, 0);
    check("R2 pin released while ignoring", dut_oe, 0);
    bus_stop();
    peek(0, v); check("R2 no write after foreign address", v, 8'h30);

    // R9 full-length read, count 19h clamps at register 20
    do_read(23, "count 19");

    check("R12 sda_oe changes with SCL high", oe_bad, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule